// File: doc/BRIEF.md
# MDIO management master controller

This block is a register-mapped master for the two-wire management bus that connects a MAC to its PHYs. Software writes a target address and payload into holding registers, then writes a command word with the start bit set. The block then shifts out one complete management frame on the clock and data pins. Each frame has a preamble of ones, a start code, an opcode, a port address, a register or device address, a turnaround and sixteen data bits. The start bit reads back as 1 for as long as the frame is on the wire, so it doubles as the busy flag. When the frame ends, the start bit clears.

Frames use either the short-address (Clause 22) format or the extended (Clause 45) format. A multi-step extended access is built in software as a sequence of single frames: first an address frame, then a data frame. In a read frame the block releases the data pin from the turnaround onward. It captures sixteen bits on rising management-clock edges and records whether the PHY pulled the second turnaround bit low. A status bit reports that outcome, and the read data register is only meaningful while that bit is clear. The management clock is derived from the system clock by a parameterised divider.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Registers sit at byte offsets 0x00 (command), 0x04 (address), 0x08 (write data), 0x0C (read data) and 0x10 (status). Address and write data hold bits 15:0 and read back with zero upper bits. Writes to 0x0C, 0x10 and unmapped offsets change nothing, and unmapped offsets read 0.
- R2: The command word holds the register/device number in bits 4:0, the port address in 9:5, the opcode in 11:10, the clause select in 13:12 and start in bit 14. Writing it with bit 14 set while idle starts one frame. Bit 14 reads 1 from the next cycle until the frame ends, then 0, and bits 13:0 read back as written.
- R3: A command write while bit 14 reads 1 is ignored. The fields, the frame on the wire and the busy flag are all unaffected, and no second frame follows.
- R4: Every frame is 64 bit times, sent MSB first: 32 ones, a 2-bit start code, the opcode, the 5-bit port address, the 5-bit register/device number, a 2-bit turnaround and 16 data bits.
- R5: A clause select of 1 sends start code 01 (Clause 22). Any other value, 0 included, sends start code 00 (Clause 45).
- R6: A non-read frame drives turnaround 10 followed by the payload. The payload is the address register for a Clause 45 opcode 0, and the write data register otherwise.
- R7: A read frame is a Clause 22 opcode 2 or a Clause 45 opcode 2 or 3. In a read frame the output enable is low for bit times 46 to 63. Sixteen bits are sampled at rising MDC edges and land in the read data register, first bit as bit 15.
- R8: At the end of each read frame, status bit 0 becomes 1 if the second turnaround bit was sampled high, and 0 otherwise. Non-read frames leave it unchanged.
- R9: MDC has a period of 2×HALF_DIV system clocks with equal high and low times. The data output and its enable change only on clock edges where MDC falls.
- R10: After reset, MDC is low, the output enable is low, busy is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Two situations are the hardest to reach from the ports. The first is a command that arrives while a frame is still on the wire. The bench writes a second command with its start bit set halfway through a frame, then checks that the captured frame, the readback fields and the busy flag all belong to the first command. The second is a PHY that fails to pull the turnaround low. A bench-side responder follows the MDC edges and drives each turnaround and data bit with the value chosen for that frame. That lets a failed read, a following write and a clean read be chained, to show when the error bit moves and when it stays put.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int OFS_CMD   = 'h00;
  localparam int OFS_ADDR  = 'h04;
  localparam int OFS_WDATA = 'h08;
  localparam int OFS_RDATA = 'h0C;
  localparam int OFS_STAT  = 'h10;

  localparam int DATA_W    = 16;
  localparam int START_BIT = 14;
  localparam int CMD_W     = 14;

  localparam logic [1:0] CLAUSE_SHORT = 2'd1;

  typedef struct packed {
    logic [1:0] clause;
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] reg_sel;
  } cmd_t;

  function automatic logic frame_is_read(cmd_t c);
    if (c.clause == CLAUSE_SHORT) return (c.op == 2'd2);
    return c.op[1];
  endfunction
endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    mdc_d = mdc_q;
    if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign fall_tick = wrap & mdc_q;
  assign rise_tick = wrap & ~mdc_q;
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fall_tick_i,
  input  logic              rise_tick_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done_o,
  output logic              rd_fail_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int FRAME_W = PRE_BITS + 2 * DATA_W;
  localparam int REL_IDX = PRE_BITS + 14;
  localparam int TA2_IDX = PRE_BITS + 15;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic               rd_q, rd_d;
  logic               o_q, o_d;
  logic               oe_q, oe_d;
  logic               ta_ok_q, ta_ok_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic               fin;
  logic [1:0]         start_code;
  logic [DATA_W-1:0]  payload;
  logic [FRAME_W-1:0] frame_w;

  always_comb begin
    start_code = (cmd_i.clause == CLAUSE_SHORT) ? 2'b01 : 2'b00;
    payload    = (cmd_i.clause != CLAUSE_SHORT && cmd_i.op == 2'd0) ? addr_i : wdata_i;
    frame_w    = {{PRE_BITS{1'b1}}, start_code, cmd_i.op, cmd_i.phy, cmd_i.reg_sel,
                  2'b10, payload};
  end

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    tx_d    = tx_q;
    rd_d    = rd_q;
    o_d     = o_q;
    oe_d    = oe_q;
    ta_ok_d = ta_ok_q;
    rx_d    = rx_q;
    fin     = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d  = 1'b1;
        cnt_d   = '0;
        tx_d    = frame_w;
        rd_d    = frame_is_read(cmd_i);
        ta_ok_d = 1'b0;
      end
    end else if (fall_tick_i) begin
      if (cnt_q == CNT_W'(FRAME_W)) begin
        fin    = 1'b1;
        busy_d = 1'b0;
        oe_d   = 1'b0;
        o_d    = 1'b1;
      end else begin
        oe_d  = !(rd_q && cnt_q >= CNT_W'(REL_IDX));
        o_d   = oe_d ? tx_q[FRAME_W-1] : 1'b1;
        tx_d  = {tx_q[FRAME_W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
      end
    end else if (rise_tick_i && rd_q) begin
      if (cnt_q == CNT_W'(TA2_IDX + 1)) ta_ok_d = !mdio_i;
      else if (cnt_q > CNT_W'(TA2_IDX + 1)) rx_d = {rx_q[DATA_W-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      tx_q    <= '0;
      rd_q    <= 1'b0;
      o_q     <= 1'b1;
      oe_q    <= 1'b0;
      ta_ok_q <= 1'b0;
      rx_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
      rd_q    <= rd_d;
      o_q     <= o_d;
      oe_q    <= oe_d;
      ta_ok_q <= ta_ok_d;
      rx_q    <= rx_d;
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = o_q;
  assign mdio_oe   = oe_q;
  assign rd_done_o = fin & rd_q;
  assign rd_fail_o = ~ta_ok_q;
  assign rd_data_o = rx_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 10,
  parameter int ADDR_W   = 5,
  parameter int REG_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  cmd_t              cmd_q, cmd_d;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;
  logic              busy;
  logic              cmd_wr, start;
  logic              fall_tick, rise_tick;
  logic              rd_done, rd_fail;
  logic [DATA_W-1:0] rd_data;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign cmd_wr = reg_we && (reg_addr == ADDR_W'(OFS_CMD)) && !busy;
  assign start  = cmd_wr && reg_wdata[START_BIT];

  always_comb begin
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    if (cmd_wr) cmd_d = cmd_t'(reg_wdata[CMD_W-1:0]);
    if (reg_we && reg_addr == ADDR_W'(OFS_ADDR))  addr_d  = reg_wdata[DATA_W-1:0];
    if (reg_we && reg_addr == ADDR_W'(OFS_WDATA)) wdata_d = reg_wdata[DATA_W-1:0];
    if (rd_done) begin
      rdata_d = rd_data;
      err_d   = rd_fail;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_CMD):   reg_rdata = REG_W'({busy, cmd_q});
      ADDR_W'(OFS_ADDR):  reg_rdata = REG_W'(addr_q);
      ADDR_W'(OFS_WDATA): reg_rdata = REG_W'(wdata_q);
      ADDR_W'(OFS_RDATA): reg_rdata = REG_W'(rdata_q);
      ADDR_W'(OFS_STAT):  reg_rdata = REG_W'(err_q);
      default:            reg_rdata = '0;
    endcase
  end

  mdio_mgmt_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mdc       (mdc),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick)
  );

  mdio_mgmt_engine #(.PRE_BITS(32)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start),
    .cmd_i       (cmd_t'(reg_wdata[CMD_W-1:0])),
    .addr_i      (addr_q),
    .wdata_i     (wdata_q),
    .fall_tick_i (fall_tick),
    .rise_tick_i (rise_tick),
    .mdio_i      (mdio_i),
    .busy_o      (busy),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .rd_done_o   (rd_done),
    .rd_fail_o   (rd_fail),
    .rd_data_o   (rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        rd_err,
  input logic [13:0] cmd_fields
);
  a_r9_pins_move_on_mdc_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc));

  a_r2_start_clears_on_mdc_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));

  a_r10_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r3_command_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(cmd_fields));

  a_r8_error_moves_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_err) |-> $fell(busy));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .busy       (busy),
  .rd_err     (err_q),
  .cmd_fields (cmd_q)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
  localparam int HALF = 2;
  localparam logic [63:0] RD_OE = 64'hFFFF_FFFF_FFFC_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;

  logic        armed = 1'b0;
  logic        seen_fall = 1'b0;
  int          mon_idx = 0;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  logic        rd_frame = 1'b0;
  logic        ta_drive = 1'b0;
  logic [15:0] resp = '0;

  always #5 clk = ~clk;

  mdio_mgmt_master #(.HALF_DIV(HALF)) u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY-side responder: drives the bit that will be sampled at the next rise
  always @(negedge mdc) begin
    if (!armed) seen_fall = 1'b0;
    else begin
      seen_fall = 1'b1;
      if (rd_frame && mon_idx == 47) mdio_i = ta_drive;
      else if (rd_frame && mon_idx >= 48 && mon_idx <= 63) mdio_i = resp[63-mon_idx];
      else mdio_i = 1'b1;
    end
  end

  always @(posedge mdc) begin
    if (!armed) mon_idx = 0;
    else if (seen_fall && mon_idx < 64) begin
      cap_o[63-mon_idx]  = mdio_o;
      cap_oe[63-mon_idx] = mdio_oe;
      mon_idx++;
    end
  end

  task automatic check(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      reg_read(5'h00, v);
      if (!v[14]) break;
    end
    armed = 1'b0;
  endtask

  function automatic logic [63:0] exp_frame(logic [1:0] cl, logic [1:0] op, logic [4:0] phy,
                                            logic [4:0] rg, logic [15:0] pay);
    return {32'hFFFF_FFFF, (cl == 2'd1) ? 2'b01 : 2'b00, op, phy, rg, 2'b10, pay};
  endfunction

  task automatic do_frame(input logic [1:0] cl, input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] av, input logic [15:0] wv,
                          input logic [15:0] rv, input logic tav);
    logic [31:0] v;
    logic [63:0] e;
    logic        is_rd;
    is_rd = (cl == 2'd1) ? (op == 2'd2) : op[1];
    reg_write(5'h04, {16'hDEAD, av});
    reg_write(5'h08, {16'hBEEF, wv});
    rd_frame = is_rd; resp = rv; ta_drive = tav;
    reg_write(5'h00, {17'd0, 1'b1, cl, op, phy, rg});
    armed = 1'b1;
    reg_read(5'h00, v);
    check(v[14] == 1'b1, "R2 busy while frame runs", 64'(v[14]), 64'd1);
    wait_idle();
    e = exp_frame(cl, op, phy, rg, (cl != 2'd1 && op == 2'd0) ? av : wv);
    check(mon_idx == 64, "R4 bit count", 64'(mon_idx), 64'd64);
    check(cap_o[63:32] == 32'hFFFF_FFFF, "R4 preamble", cap_o, e);
    check(cap_o[31:30] == e[31:30], "R5 start code", 64'(cap_o[31:30]), 64'(e[31:30]));
    reg_read(5'h00, v);
    check(v[14:0] == {1'b0, cl, op, phy, rg}, "R2 fields and start cleared",
          64'(v[14:0]), 64'({1'b0, cl, op, phy, rg}));
    if (is_rd) begin
      check(cap_o[63:18] == e[63:18], "R4 read header", cap_o, e);
      check(cap_oe == RD_OE, "R7 release", cap_oe, RD_OE);
      reg_read(5'h0C, v);
      check(v == {16'd0, rv}, "R7 read data", 64'(v), 64'(rv));
      reg_read(5'h10, v);
      check(v == 32'(tav), "R8 read error flag", 64'(v), 64'(tav));
    end else begin
      check(cap_o == e, "R6 write frame", cap_o, e);
      check(cap_oe == '1, "R4 driven frame", cap_oe, '1);
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    realtime t0, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check(mdc == 1'b0 || mdc == 1'b1, "R10 mdc known", 64'(mdc), 64'd0);
    check(mdio_oe == 1'b0, "R10 oe low", 64'(mdio_oe), 64'd0);
    for (int a = 0; a <= 16; a += 4) begin
      reg_read(5'(a), v);
      check(v == 32'd0, "R10 register reset", 64'(v), 64'd0);
    end

    // R1 register map
    reg_write(5'h04, 32'hFFFF_ABCD);
    reg_write(5'h08, 32'h1234_5678);
    reg_write(5'h0C, 32'h0000_FFFF);
    reg_write(5'h10, 32'h0000_0001);
    reg_write(5'h14, 32'hFFFF_FFFF);
    reg_read(5'h04, v); check(v == 32'h0000_ABCD, "R1 address reg", 64'(v), 64'h0000_ABCD);
    reg_read(5'h08, v); check(v == 32'h0000_5678, "R1 wdata reg", 64'(v), 64'h0000_5678);
    reg_read(5'h0C, v); check(v == 32'd0, "R1 rdata write ignored", 64'(v), 64'd0);
    reg_read(5'h10, v); check(v == 32'd0, "R1 status write ignored", 64'(v), 64'd0);
    reg_read(5'h14, v); check(v == 32'd0, "R1 unmapped reads 0", 64'(v), 64'd0);
    reg_read(5'h00, v); check(v == 32'd0, "R1 command untouched", 64'(v), 64'd0);

    // R9 MDC period and duty
    @(posedge mdc); t0 = $realtime;
    @(negedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    check((t1 - t0) == HALF * 10.0, "R9 mdc high time", 64'(int'(t1 - t0)), 64'(HALF * 10));
    check((t2 - t0) == 2 * HALF * 10.0, "R9 mdc period", 64'(int'(t2 - t0)), 64'(2 * HALF * 10));

    // Clause 22 sweep over all port addresses and opcodes
    for (int p = 0; p < 32; p++) begin
      logic [15:0] dv;
      dv = 16'(p * 16'h0931) ^ 16'hA5C3;
      do_frame(2'd1, 2'(p % 4), 5'(p), 5'(31 - p), 16'h0F0F ^ dv, dv, ~dv, 1'b0);
    end

    // Clause 45 opcodes over several device addresses
    for (int o = 0; o < 4; o++) begin
      foreach (v[k]) if (k < 3) begin
        logic [4:0] dev;
        dev = (k == 0) ? 5'd0 : (k == 1) ? 5'd17 : 5'd31;
        do_frame(2'd0, 2'(o), 5'(o * 7 + k), dev, 16'(16'h1000 + o * 16'h0111 + k),
                 16'(16'hC000 + o * 16'h0022 + k), 16'(16'h5A00 + o * 16'h0101 + k), 1'b0);
      end
    end

    // R5 other clause select codes take extended framing
    do_frame(2'd2, 2'd1, 5'd9, 5'd3, 16'h2222, 16'h3333, 16'h0, 1'b0);
    do_frame(2'd3, 2'd0, 5'd4, 5'd8, 16'h4444, 16'h5555, 16'h0, 1'b0);

    // R8 failed read, write keeps flag, clean read clears it
    do_frame(2'd1, 2'd2, 5'd1, 5'd2, 16'h0, 16'h0, 16'h9999, 1'b1);
    do_frame(2'd1, 2'd1, 5'd1, 5'd2, 16'h0, 16'h7777, 16'h0, 1'b0);
    reg_read(5'h10, v); check(v == 32'd1, "R8 write leaves error set", 64'(v), 64'd1);
    do_frame(2'd1, 2'd2, 5'd1, 5'd2, 16'h0, 16'h0, 16'h8181, 1'b0);

    // R3 command written mid-frame is ignored
    begin
      logic [63:0] e;
      reg_write(5'h08, 32'h0000_6A6A);
      rd_frame = 1'b0;
      reg_write(5'h00, {17'd0, 1'b1, 2'd1, 2'd1, 5'd21, 5'd10});
      armed = 1'b1;
      repeat (60) @(negedge clk);
      reg_write(5'h00, {17'd0, 1'b1, 2'd0, 2'd3, 5'd2, 5'd30});
      wait_idle();
      e = exp_frame(2'd1, 2'd1, 5'd21, 5'd10, 16'h6A6A);
      check(cap_o == e, "R3 frame of first command", cap_o, e);
      reg_read(5'h00, v);
      check(v[14:0] == {1'b0, 2'd1, 2'd1, 5'd21, 5'd10}, "R3 fields kept",
            64'(v[14:0]), 64'({1'b0, 2'd1, 2'd1, 5'd21, 5'd10}));
      repeat (300) @(negedge clk);
      reg_read(5'h00, v);
      check(v[14] == 1'b0, "R3 no second frame", 64'(v[14]), 64'd0);
      check(mdio_oe == 1'b0, "R3 pin released", 64'(mdio_oe), 64'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule